// File: doc/BRIEF.md
# Nonvolatile SRAM Power-Loss Store and Power-Up Recall Sequencer

This controller sits between the host access strobes and a battery-free nonvolatile SRAM array. It watches a single supply-good flag, which is high while the supply is above the low-voltage trigger level. When the flag rises, the controller runs a timed recall that copies the nonvolatile cells into the SRAM. When the flag falls, the controller runs a timed store, but only if the array holds data written since the last nonvolatile cycle. An explicit store request from the host uses the same store path. A timer models the completion of each store and recall. All durations are parameters counted in clock cycles.

The controller gates the array read and write enables. It accepts new accesses only in `ST_IDLE`. During the short `ST_GRACE` window before a store, it lets an access that was already in progress finish. It drives an active-low busy line through an output enable. The line is driven low while a store or recall is in progress. It is then driven high for a hold window. After that the driver is released and the line rests on its pull-up.

The states are `ST_OFF`, `ST_RECALL`, `ST_IDLE`, `ST_GRACE`, `ST_STORE` and `ST_RELEASE`. These are the transitions:
- OFF→RECALL when the supply rises.
- RECALL→OFF when the supply drops during recall.
- RECALL→RELEASE when the recall timer ends.
- IDLE→GRACE on a supply drop or a store request, if data is dirty.
- IDLE→OFF on a supply drop with clean data.
- GRACE→STORE when the grace timer ends.
- STORE→RELEASE when the store timer ends.
- RELEASE→OFF, →RECALL or →IDLE when the hold timer ends.

Top module: `nvs_seq`

## Requirements
- R1: While reset is active, and after it ends, the controller is in `ST_OFF`. In that state `busy_oe`=0, `busy_n`=1, and both array enables are 0.
- R2: In `ST_OFF`, a high `supply_ok` at a clock edge starts a recall lasting exactly `RECALL_CYC` cycles. During the recall `busy_oe`=1 and `busy_n`=0.
- R3: A completed recall or store is followed by exactly `HOLD_CYC` cycles with `busy_oe`=1 and `busy_n`=1. Whenever `busy_oe`=0, `busy_n` reads 1.
- R4: When the hold window ends, the next state depends on `supply_ok` and on whether it was low at any clock edge during the store sequence or the hold window:
  - `supply_ok` low: go to `ST_OFF`.
  - `supply_ok` high and it was low at such an edge: start a new recall.
  - otherwise: go to `ST_IDLE`.
- R5: In `ST_IDLE`, `arr_rd_en` follows `rd_req` and `arr_wr_en` follows `wr_req` in the same cycle.
- R6: In `ST_OFF`, `ST_RECALL`, `ST_STORE` and `ST_RELEASE`, both array enables stay 0 whatever the requests are.
- R7: A write accepted in `ST_IDLE` marks the array dirty. A completed store or recall clears the mark. A clean array makes a store request have no effect.
- R8: With the array dirty, `supply_ok` low in `ST_IDLE` runs two windows: `GRACE_CYC` cycles of grace, then `STORE_CYC` cycles of store. `busy_oe`=1 and `busy_n`=0 through both. A write accepted in the same cycle as the drop counts as dirty.
- R9: With the array clean, `supply_ok` low in `ST_IDLE` moves straight to `ST_OFF`. No store runs and the busy line is not driven.
- R10: With the array dirty, `store_req` high in `ST_IDLE` runs the same grace and store sequence as R8. Afterwards the controller returns to `ST_IDLE`.
- R11: During grace, a strobe that was enabled in the previous cycle stays enabled while its request is held. A strobe that is new or re-asserted stays blocked.
- R12: If `supply_ok` returns during a power-loss store, the store still completes, and a recall follows the hold window.
- R13: If `supply_ok` drops during a recall, the recall is abandoned and the controller enters `ST_OFF` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | High while the supply is above the trigger level |
| store_req | input | 1 | Host request for a store |
| rd_req | input | 1 | Host read strobe |
| wr_req | input | 1 | Host write strobe |
| arr_rd_en | output | 1 | Gated read enable to the array |
| arr_wr_en | output | 1 | Gated write enable to the array |
| busy_n | output | 1 | Active-low busy/handshake level |
| busy_oe | output | 1 | Output enable of the busy driver |

## Verification
A wrong state or timer count shows up at the ports within the same cycle. It appears as a busy-line level, an output-enable level or an array enable that differs from the reference, because all four outputs decode the present state combinationally. A lost or stuck dirty mark shows up one edge after the supply drop or store request, as a missing or spurious grace window on `busy_oe`. A wrong sticky power-loss flag stays hidden until the end of the hold window. At that point the controller picks the wrong successor: a recall instead of idle, or idle instead of a recall. The per-cycle comparison against the behavioural model catches each of these at its first wrong cycle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_RECALL,
        ST_IDLE,
        ST_GRACE,
        ST_STORE,
        ST_RELEASE
    } nvs_state_t;
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R2
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
endmodule

// File: rtl/nvs_gate.sv
module nvs_gate
    import nvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  nvs_state_t state,
    input  logic       rd_req,
    input  logic       wr_req,
    input  logic       clr_dirty,
    output logic       rd_en,
    output logic       wr_en,
    output logic       dirty
);
    logic rd_q, wr_q;

    always_comb begin
        unique case (state)
            ST_IDLE: begin
                rd_en = rd_req;
                wr_en = wr_req;
            end
            ST_GRACE: begin
                rd_en = rd_req && rd_q;
                wr_en = wr_req && wr_q;
            end
            default: begin
                rd_en = 1'b0;
                wr_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            dirty <= 1'b0;
        end else begin
            rd_q <= rd_en;
            wr_q <= wr_en;
            if (clr_dirty)
                dirty <= 1'b0;
            else if (wr_en && state == ST_IDLE)
                dirty <= 1'b1;
        end
    end

    // R6
    access_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> (state == ST_IDLE || state == ST_GRACE));

    // R11
    grace_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && wr_en) |-> $past(wr_en));

    // R7
    grace_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE) |-> dirty);
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int RECALL_CYC = 2000000,
    parameter int STORE_CYC  = 800000,
    parameter int GRACE_CYC  = 3,
    parameter int HOLD_CYC   = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic store_req,
    input  logic rd_req,
    input  logic wr_req,
    output logic arr_rd_en,
    output logic arr_wr_en,
    output logic busy_n,
    output logic busy_oe
);
    localparam int MAX_AB = (RECALL_CYC > STORE_CYC) ? RECALL_CYC : STORE_CYC;
    localparam int MAX_CD = (GRACE_CYC > HOLD_CYC) ? GRACE_CYC : HOLD_CYC;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    nvs_state_t state, state_d;
    logic       t_done, t_load;
    logic [CNT_W-1:0] t_val;
    logic       dirty, clr_dirty, pwr_lost;

    nvs_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    nvs_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .clr_dirty (clr_dirty),
        .rd_en     (arr_rd_en),
        .wr_en     (arr_wr_en),
        .dirty     (dirty)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:
                if (supply_ok) state_d = ST_RECALL;
            ST_RECALL:
                if (!supply_ok)  state_d = ST_OFF;
                else if (t_done) state_d = ST_RELEASE;
            ST_IDLE:
                if (!supply_ok || store_req) begin
                    if (dirty || arr_wr_en) state_d = ST_GRACE;
                    else if (!supply_ok)    state_d = ST_OFF;
                end
            ST_GRACE:
                if (t_done) state_d = ST_STORE;
            ST_STORE:
                if (t_done) state_d = ST_RELEASE;
            ST_RELEASE:
                if (t_done) begin
                    if (!supply_ok)   state_d = ST_OFF;
                    else if (pwr_lost) state_d = ST_RECALL;
                    else              state_d = ST_IDLE;
                end
            default:
                state_d = ST_OFF;
        endcase
    end

    // timer reload on every state entry
    always_comb begin
        t_load = (state_d != state);
        unique case (state_d)
            ST_RECALL:  t_val = CNT_W'(RECALL_CYC - 1);
            ST_GRACE:   t_val = CNT_W'(GRACE_CYC - 1);
            ST_STORE:   t_val = CNT_W'(STORE_CYC - 1);
            ST_RELEASE: t_val = CNT_W'(HOLD_CYC - 1);
            default:    t_val = '0;
        endcase
    end

    assign clr_dirty = (state_d == ST_RELEASE) && (state != ST_RELEASE);

    // state register and sticky power-loss flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            pwr_lost <= 1'b0;
        end else begin
            state <= state_d;
            if (state_d == ST_OFF || (state == ST_RELEASE && state_d != ST_RELEASE))
                pwr_lost <= 1'b0;
            else if (!supply_ok && state != ST_OFF && state != ST_RECALL)
                pwr_lost <= 1'b1;
        end
    end

    // handshake outputs
    always_comb begin
        unique case (state)
            ST_RECALL, ST_GRACE, ST_STORE: begin
                busy_oe = 1'b1;
                busy_n  = 1'b0;
            end
            ST_RELEASE: begin
                busy_oe = 1'b1;
                busy_n  = 1'b1;
            end
            default: begin
                busy_oe = 1'b0;
                busy_n  = 1'b1;
            end
        endcase
    end

    // R3
    released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_oe |-> busy_n);

    // R8
    idle_leaves_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !supply_ok) |=> (state != ST_IDLE));

    // R12
    store_runs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE) |=> (state == ST_STORE || state == ST_RELEASE));

    // R13
    recall_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECALL && !supply_ok) |=> (state == ST_OFF));
endmodule

// File: tb/sim_nvs_seq.sv
module sim_nvs_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RC = 20;
    localparam int SC = 12;
    localparam int GC = 3;
    localparam int HC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup = 1'b0, sreq = 1'b0, rd = 1'b0, wr = 1'b0;
    logic a_rd, a_wr, b_n, b_oe;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string phase = "R1";

    // model: 0 off, 1 recall, 2 idle, 3 grace, 4 store, 5 hold-high
    int ms = 0;
    int rem = 0;
    bit m_dirty = 0, m_pwr = 0, m_prd = 0, m_pwr_w = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvs_seq #(.RECALL_CYC(RC), .STORE_CYC(SC), .GRACE_CYC(GC), .HOLD_CYC(HC)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(sup), .store_req(sreq),
        .rd_req(rd), .wr_req(wr), .arr_rd_en(a_rd), .arr_wr_en(a_wr),
        .busy_n(b_n), .busy_oe(b_oe)
    );

    function automatic bit g_rd();
        return (ms == 2) ? rd : ((ms == 3) ? (rd && m_prd) : 1'b0);
    endfunction
    function automatic bit g_wr();
        return (ms == 2) ? wr : ((ms == 3) ? (wr && m_pwr_w) : 1'b0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; rem = 0; m_dirty = 0; m_pwr = 0; m_prd = 0; m_pwr_w = 0;
        end else begin
            bit gr, gw;
            gr = g_rd();
            gw = g_wr();
            m_prd = gr;
            m_pwr_w = gw;
            case (ms)
                0: if (sup) begin ms = 1; rem = RC; end
                1: if (!sup) ms = 0;
                   else if (rem == 1) begin m_dirty = 0; ms = 5; rem = HC; end
                   else rem--;
                2: begin
                    if (gw) m_dirty = 1;
                    if (!sup) begin
                        if (m_dirty) begin ms = 3; rem = GC; m_pwr = 1; end
                        else ms = 0;
                    end else if (sreq && m_dirty) begin
                        ms = 3; rem = GC;
                    end
                end
                3: begin
                    if (!sup) m_pwr = 1;
                    if (rem == 1) begin ms = 4; rem = SC; end else rem--;
                end
                4: begin
                    if (!sup) m_pwr = 1;
                    if (rem == 1) begin m_dirty = 0; ms = 5; rem = HC; end else rem--;
                end
                default: begin
                    if (!sup) m_pwr = 1;
                    if (rem == 1) begin
                        if (!sup) ms = 0;
                        else if (m_pwr) begin ms = 1; rem = RC; end
                        else ms = 2;
                        m_pwr = 0;
                    end else rem--;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        bit e_rd, e_wr, e_oe, e_n;
        e_rd = g_rd();
        e_wr = g_wr();
        e_oe = (ms == 1 || ms == 3 || ms == 4 || ms == 5);
        e_n  = !(ms == 1 || ms == 3 || ms == 4);
        compared++;
        if (a_rd !== e_rd || a_wr !== e_wr || b_oe !== e_oe || b_n !== e_n) begin
            mismatched++;
            $display("FAIL %s t=%0t rd/wr/oe/n actual=%b%b%b%b expected=%b%b%b%b",
                     phase, $time, a_rd, a_wr, b_oe, b_n, e_rd, e_wr, e_oe, e_n);
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired in phase %s", phase);
            report();
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state; requests ignored while off (R6)
        tick(3);
        rst_n = 1'b1;
        rd = 1'b1; wr = 1'b1;
        tick(3);
        // R2: power-up recall with requests held (R6)
        phase = "R2";
        sup = 1'b1;
        tick(RC);
        // R3: hold-high window, then idle (R4)
        phase = "R3";
        rd = 1'b0; wr = 1'b0;
        tick(HC + 2);
        // R10: store request on a clean array has no effect
        phase = "R10";
        sreq = 1'b1; tick(1); sreq = 1'b0; tick(3);
        // R9: clean supply drop goes straight off
        phase = "R9";
        sup = 1'b0; tick(3);
        phase = "R2";
        sup = 1'b1; tick(RC + HC + 2);
        // R5: reads and writes pass in idle; R7 write marks dirty
        phase = "R5";
        rd = 1'b1; tick(2); rd = 1'b0;
        wr = 1'b1; tick(1); wr = 1'b0; tick(2);
        // R10 and R11: held write survives grace, new strobes blocked
        phase = "R11";
        wr = 1'b1; sreq = 1'b1; tick(1);
        sreq = 1'b0; tick(2);
        wr = 1'b0; tick(1);
        rd = 1'b1; tick(1);
        rd = 1'b0; wr = 1'b1; tick(1);
        wr = 1'b0;
        phase = "R10";
        tick(SC + HC + 2);
        // R7: dirty cleared by the store, so a new request is ignored
        phase = "R7";
        sreq = 1'b1; tick(1); sreq = 1'b0; tick(3);
        // R12: supply returns during a power-loss store
        phase = "R12";
        wr = 1'b1; tick(1); wr = 1'b0;
        sup = 1'b0; tick(5);
        sup = 1'b1; tick(GC + SC + HC + RC + HC + 4);
        // R8: write in the same cycle as the drop forces a store; R4 ends off
        phase = "R8";
        wr = 1'b1; sup = 1'b0; tick(1);
        wr = 1'b0; tick(GC + SC + HC + 3);
        // R13: supply lost during recall
        phase = "R13";
        sup = 1'b1; tick(5);
        sup = 1'b0; tick(3);
        sup = 1'b1; tick(RC + HC + 3);
        // R4: manual store with a supply dip leads to a recall
        phase = "R4";
        wr = 1'b1; tick(1); wr = 1'b0;
        sreq = 1'b1; tick(1); sreq = 1'b0;
        tick(GC + 2);
        sup = 1'b0; tick(1); sup = 1'b1;
        tick(SC + HC + RC + HC + 4);
        report();
    end
endmodule